// File: doc/BRIEF.md
# Multi-format serial PCM receiver

This block takes stereo PCM audio from a single serial data line. It uses a bit clock and a left/right frame clock, and returns one parallel sample per channel. A 2-bit format select picks one of four framings:

- two LSB-justified framings (16-bit and 18-bit), where the sample sits at the end of each half-frame;
- a 24-bit MSB-justified framing;
- a 24-bit I2S-style framing.

Each sample comes out as a 24-bit two's-complement word. A one-cycle valid strobe and a channel flag go with it. Words from the shorter framings are sign-extended to 24 bits.

All logic runs in the bit-clock domain and samples on the rising edge. The frame clock is compared with its previous value to find half-frame boundaries. The first boundary seen after reset only sets the alignment. The bit and frame clocks come from outside, and the format bits are driven by a register elsewhere in the chip. Integration must hold the format select steady while audio flows and hold the frame clock low while reset is asserted.

Top module: `serial_pcm_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first word completes, `outValid`, `outRight` and `outWord` are all zero.
- R2: The format codes on `fmtSel` are: 0 = 16-bit LSB-justified, 1 = 18-bit LSB-justified, 2 = 24-bit MSB-justified, 3 = 24-bit I2S-style. In every mode, data is MSB first and is sampled on the rising bit-clock edge.
- R3: In mode 0, the word is built from the last 16 bits sampled before the frame-clock transition that ends the half-frame. The word is sign-extended from bit 15, and every earlier bit in that half-frame has no effect. Frame clock high marks the left channel. The mode works at 32 or more bit clocks per frame.
- R4: In mode 1, the word is built the same way from the last 18 bits, sign-extended from bit 17. Frame clock high marks the left channel. The mode works at 36 or more bit clocks per frame.
- R5: In mode 2, the MSB is the bit sampled on the first rising edge that sees the new frame-clock level. The next 23 bits follow it, and any bits after the 24th have no effect. Frame clock high marks the left channel. A 16-bit stream padded with zeros comes out unchanged, with bits 7:0 zero. The mode works at 48 or more bit clocks per frame.
- R6: In mode 3, the MSB is sampled one bit clock after the edge that sees the new frame-clock level, and 24 bits are captured. Frame clock low marks the left channel. The mode works at 48 or more bit clocks per frame.
- R7: In mode 3 at exactly 32 bit clocks per frame, the 16th bit arrives on the first edge of the following half-frame. It completes the word, which comes out with the 16 bits in bits 23:8 and bits 7:0 zero.
- R8: `outValid` is a single-cycle pulse, and there is exactly one per captured channel. `outRight` is 1 for right-channel words. The pulse comes one cycle after the edge that completes the word:
  - in modes 2 and 3, the edge that samples the last captured bit;
  - in modes 0 and 1, the edge that sees the frame-clock transition.
- R9: The first frame-clock transition after reset produces no word. Bits sampled before it never reach `outWord`. In modes 0 and 1, a half-frame produces a word only if it began with an observed transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock; all state updates on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fmtSel | input | 2 | Framing select (0..3, see R2) |
| frameClk | input | 1 | Left/right frame clock |
| serData | input | 1 | Serial audio data |
| outWord | output | 24 | Captured sample, two's complement |
| outValid | output | 1 | One-cycle strobe for a new word |
| outRight | output | 1 | 1 when `outWord` belongs to the right channel |

## Verification
The hardest case to reach from the ports is the I2S-style frame at 32 bit clocks. There, the last bit of a word lands in the edge cycle of the next half-frame, the same cycle in which a new channel begins. The bench reaches it by generating every bit position from a per-mode rule. The final bit of one channel is carried into position zero of the next half-frame, and a short trailing half-frame flushes the last word. The alignment rule is exercised by a run of junk bits before the first transition in every scenario, which must yield no word.

// File: rtl/serial_pcm_rx_pkg.sv
package serial_pcm_rx_pkg;
  localparam int WORD_W = 24;
  localparam int IDX_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    FMT_LSB16 = 2'd0,
    FMT_LSB18 = 2'd1,
    FMT_MSB24 = 2'd2,
    FMT_I2S24 = 2'd3
  } fmt_e;

  // strobes from control to datapath, valid in the current bit-clock cycle
  typedef struct packed {
    logic             take;      // write serData into the word at bitIdx
    logic [IDX_W-1:0] bitIdx;    // 0 = MSB
    logic             emitFull;  // word complete after this bit
    logic             emitTail;  // I2S short frame: last bit at boundary
    logic             emitLsb;   // LSB-justified word ends at boundary
    logic             lsbMid;    // 1: 18-bit LSB word, 0: 16-bit
    logic             chanRight; // channel of the word being emitted
  } rx_strobe_t;
endpackage

// File: rtl/serial_pcm_rx_ctrl.sv
module serial_pcm_rx_ctrl
  import serial_pcm_rx_pkg::*;
(
  input  logic       bitClk,
  input  logic       rstN,
  input  logic [1:0] fmtSel,
  input  logic       frameClk,
  output rx_strobe_t st
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] FULL_CNT  = IDX_W'(WORD_W);

  fmt_e             fmt;
  logic             lrPrev;
  logic             armed;
  logic [IDX_W-1:0] taken;
  logic             lrEdge;

  assign fmt    = fmt_e'(fmtSel);
  assign lrEdge = (frameClk != lrPrev);

  always_comb begin
    st = '0;
    st.lsbMid = (fmt == FMT_LSB18);
    unique case (fmt)
      FMT_MSB24: begin
        st.chanRight = ~frameClk;
        if (lrEdge) begin
          st.take   = 1'b1;
          st.bitIdx = '0;
        end else if (armed && taken < FULL_CNT) begin
          st.take   = 1'b1;
          st.bitIdx = taken;
        end
        st.emitFull = st.take && (st.bitIdx == LAST_IDX);
      end
      FMT_I2S24: begin
        if (lrEdge) begin
          st.chanRight = lrPrev;
          if (armed && taken != '0 && taken < FULL_CNT) begin
            st.take     = 1'b1;
            st.bitIdx   = taken;
            st.emitTail = 1'b1;
          end
        end else begin
          st.chanRight = frameClk;
          if (armed && taken < FULL_CNT) begin
            st.take   = 1'b1;
            st.bitIdx = taken;
          end
          st.emitFull = st.take && (st.bitIdx == LAST_IDX);
        end
      end
      default: begin
        st.chanRight = ~lrPrev;
        st.emitLsb   = lrEdge && armed;
      end
    endcase
  end

  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      lrPrev <= 1'b0;
      armed  <= 1'b0;
      taken  <= '0;
    end else begin
      lrPrev <= frameClk;
      if (lrEdge) begin
        armed <= 1'b1;
        taken <= (fmt == FMT_MSB24) ? IDX_W'(1) : '0;
      end else if (st.take) begin
        taken <= taken + IDX_W'(1);
      end
    end
  end

  assert_single_emit_R8: assert property (@(posedge bitClk) disable iff (!rstN)
    $onehot0({st.emitFull, st.emitTail, st.emitLsb}));

  assert_taken_bound_R6: assert property (@(posedge bitClk) disable iff (!rstN)
    taken <= FULL_CNT);

  assert_no_emit_unaligned_R9: assert property (@(posedge bitClk) disable iff (!rstN)
    !armed |-> !(st.emitFull || st.emitTail || st.emitLsb));

  assert_tail_at_boundary_R7: assert property (@(posedge bitClk) disable iff (!rstN)
    st.emitTail |-> (fmt == FMT_I2S24 && frameClk != lrPrev));
endmodule

// File: rtl/serial_pcm_rx_dp.sv
module serial_pcm_rx_dp
  import serial_pcm_rx_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int MID_W   = 18
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              serData,
  input  rx_strobe_t        st,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  output logic              outRight
);
  localparam int PAD_SHORT = WORD_W - SHORT_W;
  localparam int PAD_MID   = WORD_W - MID_W;

  logic [MID_W-1:0]  tailSr;   // most recent bits, newest in bit 0
  logic [WORD_W-1:0] accWord;
  logic [WORD_W-1:0] wordNext;
  logic [WORD_W-1:0] lsbWord;

  always_comb begin
    wordNext = (st.bitIdx == '0) ? '0 : accWord;
    for (int i = 0; i < WORD_W; i++) begin
      if (st.bitIdx == IDX_W'(WORD_W - 1 - i)) wordNext[i] = serData;
    end
  end

  assign lsbWord = st.lsbMid
    ? {{PAD_MID{tailSr[MID_W-1]}}, tailSr}
    : {{PAD_SHORT{tailSr[SHORT_W-1]}}, tailSr[SHORT_W-1:0]};

  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      tailSr   <= '0;
      accWord  <= '0;
      outWord  <= '0;
      outValid <= 1'b0;
      outRight <= 1'b0;
    end else begin
      tailSr   <= {tailSr[MID_W-2:0], serData};
      outValid <= st.emitFull || st.emitTail || st.emitLsb;
      if (st.take) accWord <= wordNext;
      if (st.emitFull || st.emitTail) begin
        outWord  <= wordNext;
        outRight <= st.chanRight;
      end else if (st.emitLsb) begin
        outWord  <= lsbWord;
        outRight <= st.chanRight;
      end
    end
  end

  assert_pulse_width_R8: assert property (@(posedge bitClk) disable iff (!rstN)
    outValid |=> !outValid);

  assert_sext_short_R3: assert property (@(posedge bitClk) disable iff (!rstN)
    (st.emitLsb && !st.lsbMid) |=>
      (outWord[WORD_W-1:SHORT_W-1] == '0 || (&outWord[WORD_W-1:SHORT_W-1])));

  assert_sext_mid_R4: assert property (@(posedge bitClk) disable iff (!rstN)
    (st.emitLsb && st.lsbMid) |=>
      (outWord[WORD_W-1:MID_W-1] == '0 || (&outWord[WORD_W-1:MID_W-1])));
endmodule

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx
  import serial_pcm_rx_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int MID_W   = 18
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic [1:0]        fmtSel,
  input  logic              frameClk,
  input  logic              serData,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  output logic              outRight
);
  rx_strobe_t st;

  serial_pcm_rx_ctrl u_ctrl (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .fmtSel   (fmtSel),
    .frameClk (frameClk),
    .st       (st)
  );

  serial_pcm_rx_dp #(.SHORT_W(SHORT_W), .MID_W(MID_W)) u_dp (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .serData  (serData),
    .st       (st),
    .outWord  (outWord),
    .outValid (outValid),
    .outRight (outRight)
  );
endmodule

// File: tb/serial_pcm_rx_bench.sv
module serial_pcm_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic        bitClk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  fmtSel = 2'd3;
  logic        frameClk = 1'b0;
  logic        serData = 1'b0;
  logic [23:0] outWord;
  logic        outValid;
  logic        outRight;

  int nTests = 0;
  int nFail  = 0;

  logic [23:0] expWord[$];
  logic        expRight[$];
  string       expTag[$];
  logic        prevValid = 1'b0;
  logic        tailBit = 1'b0;

  always #(CLK_PERIOD/2) bitClk = ~bitClk;

  serial_pcm_rx u_serial_pcm_rx (
    .bitClk(bitClk), .rstN(rstN), .fmtSel(fmtSel), .frameClk(frameClk),
    .serData(serData), .outWord(outWord), .outValid(outValid), .outRight(outRight)
  );

  // scoreboard: every strobe must match the next expected word (R8, R9)
  always @(negedge bitClk) begin
    if (rstN && outValid) begin
      nTests++;
      if (expWord.size() == 0) begin
        nFail++;
        $display("FAIL R9 unexpected word: actual %h right=%0b, expected none", outWord, outRight);
      end else begin
        logic [23:0] w;
        logic r;
        string t;
        w = expWord.pop_front();
        r = expRight.pop_front();
        t = expTag.pop_front();
        if (outWord !== w || outRight !== r) begin
          nFail++;
          $display("FAIL %s word: actual %h right=%0b, expected %h right=%0b", t, outWord, outRight, w, r);
        end
      end
    end
    if (rstN && outValid && prevValid) begin
      nTests++;
      nFail++;
      $display("FAIL R8 strobe longer than one cycle: actual 2+ cycles, expected 1");
    end
    prevValid = outValid;
  end

  function automatic logic bitAt(input logic [1:0] mode, input int p, input int n,
                                 input logic [23:0] s);
    logic junk;
    junk = ((p % 3) == 0);
    case (mode)
      2'd0:    return (p >= n - 16) ? s[n-1-p] : junk;
      2'd1:    return (p >= n - 18) ? s[n-1-p] : junk;
      2'd2:    return (p < 24) ? s[23-p] : junk;
      default: return (p == 0) ? tailBit : ((p <= 24) ? s[24-p] : junk);
    endcase
  endfunction

  function automatic logic [23:0] expOf(input logic [1:0] mode, input int n,
                                        input logic [23:0] s);
    case (mode)
      2'd0:    return {{8{s[15]}}, s[15:0]};
      2'd1:    return {{6{s[17]}}, s[17:0]};
      2'd2:    return s;
      default: return (n >= 24) ? s : (s & ~((24'h1 << (24 - n)) - 24'h1));
    endcase
  endfunction

  task automatic playHalf(input logic [1:0] mode, input logic lvl, input int n,
                          input logic [23:0] s, input bit expectIt, input string tag);
    if (expectIt) begin
      expWord.push_back(expOf(mode, n, s));
      expRight.push_back((mode == 2'd3) ? lvl : ~lvl);
      expTag.push_back(tag);
    end
    for (int p = 0; p < n; p++) begin
      @(negedge bitClk);
      frameClk = lvl;
      serData  = bitAt(mode, p, n, s);
    end
    tailBit = (n <= 24) ? s[24-n] : 1'b0;
  endtask

  task automatic doReset(input logic [1:0] mode);
    @(negedge bitClk);
    rstN = 1'b0;
    fmtSel = mode;
    frameClk = 1'b0;
    serData = 1'b0;
    repeat (3) @(negedge bitClk);
    rstN = 1'b1;
  endtask

  task automatic checkDrained(input string tag);
    repeat (6) @(negedge bitClk);
    nTests++;
    if (expWord.size() != 0) begin
      nFail++;
      $display("FAIL %s missing words: actual %0d outstanding, expected 0", tag, expWord.size());
    end
    expWord.delete();
    expRight.delete();
    expTag.delete();
  endtask

  // one scenario: junk before first transition, then L,R,L,R, then a short flush
  task automatic runStream(input logic [1:0] mode, input int n, input string tag,
                           input logic [23:0] s0, input logic [23:0] s1,
                           input logic [23:0] s2, input logic [23:0] s3);
    logic leftLvl;
    leftLvl = (mode == 2'd3) ? 1'b0 : 1'b1;
    doReset(mode);
    playHalf(mode, 1'b0, 20, 24'hFFFFFF, 1'b0, tag);         // R9 pre-alignment junk
    if (mode == 2'd3) playHalf(mode, 1'b1, n, 24'h5A3C96, 1'b1, tag);
    playHalf(mode, leftLvl,  n, s0, 1'b1, tag);
    playHalf(mode, ~leftLvl, n, s1, 1'b1, tag);
    playHalf(mode, leftLvl,  n, s2, 1'b1, tag);
    playHalf(mode, ~leftLvl, n, s3, 1'b1, tag);
    playHalf(mode, leftLvl,  3, 24'h0, 1'b0, tag);            // flush boundary
    checkDrained(tag);
  endtask

  task automatic testReset();
    @(negedge bitClk);
    rstN = 1'b0;
    serData = 1'b1;
    frameClk = 1'b0;
    repeat (3) @(negedge bitClk);
    nTests++;
    if (outValid !== 1'b0 || outRight !== 1'b0 || outWord !== 24'h0) begin
      nFail++;
      $display("FAIL R1 reset outputs: actual v=%0b r=%0b w=%h, expected 0 0 000000",
               outValid, outRight, outWord);
    end
    rstN = 1'b1;
    repeat (4) @(negedge bitClk);
    nTests++;
    if (outValid !== 1'b0 || outWord !== 24'h0) begin
      nFail++;
      $display("FAIL R1 idle after reset: actual v=%0b w=%h, expected 0 000000", outValid, outWord);
    end
  endtask

  task automatic testLsb16();   // R2,R3: positive and negative, minimum and wide frames
    runStream(2'd0, 16, "R3", 24'h001234, 24'h008001, 24'h007FFF, 24'h00FFFF);
    runStream(2'd0, 32, "R3", 24'hAB5A5A, 24'h00C3C3, 24'h000001, 24'h008000);
  endtask

  task automatic testLsb18();   // R4
    runStream(2'd1, 18, "R4", 24'h01ABCD, 24'h020001, 24'h03FFFF, 24'h000100);
    runStream(2'd1, 32, "R4", 24'h02AAAA, 24'h015555, 24'h000000, 24'h020000);
  endtask

  task automatic testMsb24();   // R5, including a zero-padded 16-bit stream
    runStream(2'd2, 24, "R5", 24'h123456, 24'h89ABCD, 24'h800001, 24'h7FFFFE);
    runStream(2'd2, 32, "R5", 24'h123400, 24'hFEDC00, 24'h800000, 24'h000100);
  endtask

  task automatic testI2s();     // R6 at 48 and 64 bit clocks, R7 at 32
    runStream(2'd3, 24, "R6", 24'hC0FFEE, 24'h135799, 24'h800000, 24'h000001);
    runStream(2'd3, 32, "R6", 24'h7E57AB, 24'hBADA55, 24'h0F0F0F, 24'hF0F0F0);
    runStream(2'd3, 16, "R7", 24'hBEEF00, 24'h1234FF, 24'h800100, 24'h0001AA);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nTests++;
    nFail++;
    $display("FAIL R8 watchdog expired: actual hang, expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    testReset();
    testLsb16();
    testLsb18();
    testMsb24();
    testI2s();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule